// File: doc/BRIEF.md
# Privilege Mode and System-Call Trap Unit

This block keeps the privilege state of a processor core and carries out the move between user and supervisor mode. It holds four things: a one-bit mode, an exception-enable bit with a shadow copy, an exception program counter, and a bank of memory protection bound registers. It also holds the program counter that fetch is to be redirected to. Three kinds of request reach it: a system-call strobe that comes with the PC of the calling instruction, a return-from-trap strobe, and a control-register write port.

A system call saves the caller's PC, points fetch at a fixed supervisor entry address, raises privilege and masks exceptions, all in one clock edge. A return-from-trap that supervisor code issues sends fetch back to the saved PC and drops the core to user mode. In user mode every control-register write and every return-from-trap is refused, and a one-cycle illegal-access pulse reports the refusal to the exception logic around the block.

All outputs are registered. A request presented before a rising clock edge shows on the outputs right after that edge.

Top module: `priv_trap_unit`

## Requirements
- R1: After reset the mode output is 1 (supervisor), the exception-enable output is 0, the next PC equals the reset vector, the saved PC and every bound register are 0, and the illegal flag is low.
- R2: A system call, in either mode, makes the outputs after the next edge show mode 1, saved PC equal to the PC presented with the call, and next PC equal to the trap vector.
- R3: A system call clears the exception-enable bit and copies its previous value into the shadow bit. A later accepted return-from-trap copies the shadow bit back into the exception-enable bit.
- R4: A return-from-trap accepted in supervisor mode sets the next PC to the saved PC and the mode to 0 (user).
- R5: In user mode a control-register write with no system call in the same cycle changes no register, and the illegal flag is high in the following cycle.
- R6: In user mode a return-from-trap changes nothing, and the illegal flag is high in the following cycle.
- R7: When a system call arrives in the same cycle as a control-register write or a return-from-trap, only the system call takes effect and the illegal flag stays low.
- R8: Supervisor-mode writes use this map. Address 0 is status: bit 0 is mode, bit 1 is exception enable, bit 2 is the shadow enable. Address 1 is the saved PC. Address 2+k is bound register k. A write to any other address changes nothing and raises no flag.
- R9: The illegal flag is low in any cycle that does not directly follow a refused user-mode write or return.
- R10: In supervisor mode, a return-from-trap and a control-register write in the same cycle perform the return and drop the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| syscall_i | input | 1 | System-call strobe |
| sys_pc_i | input | XLEN | PC of the calling instruction |
| trap_ret_i | input | 1 | Return-from-trap strobe |
| csr_we_i | input | 1 | Control-register write enable |
| csr_addr_i | input | AW | Control-register address |
| csr_wdata_i | input | XLEN | Control-register write data |
| mode_o | output | 1 | 1 = supervisor, 0 = user |
| next_pc_o | output | XLEN | PC fetch is redirected to |
| epc_o | output | XLEN | Saved exception PC |
| exc_en_o | output | 1 | Exception-enable bit |
| bounds_o | output | NUM_BOUNDS*BW | Protection bound registers, bound k at bits [k*BW +: BW] |
| illegal_o | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench drives the unit through a full round trip: supervisor setup writes, a return to user mode, refused user writes and returns, then a system call and another return. This shows that the mode and the shadow enable bit travel correctly in both directions. Collisions are tried separately, with a call on top of a write, a call on top of a return, and a return on top of a write. These separate the priority order from the plain user-mode refusal, because only the refusal raises the flag. An idle cycle after the refusals and a write to an unmapped address show that the flag is a single pulse and is tied to privilege, not to the address.

// File: rtl/priv_pkg.sv
package priv_pkg;

  typedef enum logic {
    MODE_USER  = 1'b0,
    MODE_SUPER = 1'b1
  } priv_mode_e;

  // control register map
  localparam int unsigned CSR_STATUS     = 0;
  localparam int unsigned CSR_EPC        = 1;
  localparam int unsigned CSR_BOUND_BASE = 2;

  // status field positions
  localparam int unsigned ST_MODE_BIT  = 0;
  localparam int unsigned ST_EXC_BIT   = 1;
  localparam int unsigned ST_SHADW_BIT = 2;

  typedef struct packed {
    logic take_sys;
    logic take_ret;
    logic wr_status;
    logic wr_epc;
    logic flag_illegal;
  } priv_req_t;

endpackage

// File: rtl/priv_rst_sync.sv
module priv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/priv_req_decode.sv
module priv_req_decode
  import priv_pkg::*;
#(
  parameter int unsigned AW         = 4,
  parameter int unsigned NUM_BOUNDS = 2
) (
  input  priv_mode_e            mode_i,
  input  logic                  syscall_i,
  input  logic                  ret_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  output priv_req_t             req_o,
  output logic [NUM_BOUNDS-1:0] bound_sel_o
);
  logic is_super;
  assign is_super = (mode_i == MODE_SUPER);

  // priority: system call, then return, then register write
  always_comb begin
    req_o       = '0;
    bound_sel_o = '0;
    if (syscall_i) begin
      req_o.take_sys = 1'b1;
    end else if (ret_i) begin
      if (is_super) req_o.take_ret     = 1'b1;
      else          req_o.flag_illegal = 1'b1;
    end else if (we_i) begin
      if (!is_super) begin
        req_o.flag_illegal = 1'b1;
      end else begin
        req_o.wr_status = (addr_i == AW'(CSR_STATUS));
        req_o.wr_epc    = (addr_i == AW'(CSR_EPC));
        for (int k = 0; k < int'(NUM_BOUNDS); k++) begin
          bound_sel_o[k] = (addr_i == AW'(CSR_BOUND_BASE + k));
        end
      end
    end
  end
endmodule

// File: rtl/priv_state.sv
module priv_state
  import priv_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 'h100,
  parameter logic [XLEN-1:0] TRAP_VEC  = 'h200
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  priv_req_t       req_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] wdata_i,
  output priv_mode_e      mode_o,
  output logic            exc_en_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] npc_o,
  output logic            illegal_o
);
  priv_mode_e      mode_q, mode_d;
  logic            exc_q, exc_d;
  logic            shadw_q, shadw_d;
  logic [XLEN-1:0] epc_q, epc_d;
  logic [XLEN-1:0] npc_q, npc_d;
  logic            ill_q;
  logic            upd_en;

  assign upd_en = req_i.take_sys | req_i.take_ret | req_i.wr_status | req_i.wr_epc;

  always_comb begin
    mode_d  = mode_q;
    exc_d   = exc_q;
    shadw_d = shadw_q;
    epc_d   = epc_q;
    npc_d   = npc_q;
    if (req_i.take_sys) begin
      shadw_d = exc_q;
      exc_d   = 1'b0;
      epc_d   = pc_i;
      npc_d   = TRAP_VEC;
      mode_d  = MODE_SUPER;
    end else if (req_i.take_ret) begin
      npc_d  = epc_q;
      mode_d = MODE_USER;
      exc_d  = shadw_q;
    end else begin
      if (req_i.wr_status) begin
        mode_d  = priv_mode_e'(wdata_i[ST_MODE_BIT]);
        exc_d   = wdata_i[ST_EXC_BIT];
        shadw_d = wdata_i[ST_SHADW_BIT];
      end
      if (req_i.wr_epc) begin
        epc_d = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_SUPER;
      exc_q   <= 1'b0;
      shadw_q <= 1'b0;
      epc_q   <= '0;
      npc_q   <= RESET_VEC;
    end else if (upd_en) begin
      mode_q  <= mode_d;
      exc_q   <= exc_d;
      shadw_q <= shadw_d;
      epc_q   <= epc_d;
      npc_q   <= npc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ill_q <= 1'b0;
    else         ill_q <= req_i.flag_illegal;
  end

  assign mode_o    = mode_q;
  assign exc_en_o  = exc_q;
  assign epc_o     = epc_q;
  assign npc_o     = npc_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/priv_bound_bank.sv
module priv_bound_bank #(
  parameter int unsigned NUM_BOUNDS = 2,
  parameter int unsigned BW         = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_BOUNDS-1:0]    sel_i,
  input  logic [BW-1:0]            wdata_i,
  output logic [NUM_BOUNDS*BW-1:0] bounds_o
);
  for (genvar g = 0; g < int'(NUM_BOUNDS); g++) begin : g_bound
    logic [BW-1:0] bnd_q;
    logic [BW-1:0] bnd_d;

    always_comb begin
      bnd_d = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bnd_q <= '0;
      end else if (sel_i[g]) begin
        bnd_q <= bnd_d;
      end
    end

    assign bounds_o[g*BW +: BW] = bnd_q;
  end
endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
  import priv_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     BW         = 32,
  parameter int unsigned     NUM_BOUNDS = 2,
  parameter int unsigned     AW         = 4,
  parameter int unsigned     SYNC_STG   = 2,
  parameter logic [XLEN-1:0] RESET_VEC  = 'h100,
  parameter logic [XLEN-1:0] TRAP_VEC   = 'h200
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     syscall_i,
  input  logic [XLEN-1:0]          sys_pc_i,
  input  logic                     trap_ret_i,
  input  logic                     csr_we_i,
  input  logic [AW-1:0]            csr_addr_i,
  input  logic [XLEN-1:0]          csr_wdata_i,
  output logic                     mode_o,
  output logic [XLEN-1:0]          next_pc_o,
  output logic [XLEN-1:0]          epc_o,
  output logic                     exc_en_o,
  output logic [NUM_BOUNDS*BW-1:0] bounds_o,
  output logic                     illegal_o
);
  localparam int unsigned MAP_SIZE = CSR_BOUND_BASE + NUM_BOUNDS;
  localparam int unsigned MIN_AW   = $clog2(MAP_SIZE);

  if (AW < MIN_AW || BW > XLEN) begin : g_bad_cfg
    initial $fatal(1, "priv_trap_unit: AW too small or BW wider than XLEN");
  end

  logic                  rst_sync_n;
  priv_mode_e            mode;
  priv_req_t             req;
  logic [NUM_BOUNDS-1:0] bound_sel;

  priv_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  priv_req_decode #(.AW(AW), .NUM_BOUNDS(NUM_BOUNDS)) u_dec (
    .mode_i     (mode),
    .syscall_i  (syscall_i),
    .ret_i      (trap_ret_i),
    .we_i       (csr_we_i),
    .addr_i     (csr_addr_i),
    .req_o      (req),
    .bound_sel_o(bound_sel)
  );

  priv_state #(.XLEN(XLEN), .RESET_VEC(RESET_VEC), .TRAP_VEC(TRAP_VEC)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .req_i    (req),
    .pc_i     (sys_pc_i),
    .wdata_i  (csr_wdata_i),
    .mode_o   (mode),
    .exc_en_o (exc_en_o),
    .epc_o    (epc_o),
    .npc_o    (next_pc_o),
    .illegal_o(illegal_o)
  );

  priv_bound_bank #(.NUM_BOUNDS(NUM_BOUNDS), .BW(BW)) u_bnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .sel_i   (bound_sel),
    .wdata_i (csr_wdata_i[BW-1:0]),
    .bounds_o(bounds_o)
  );

  assign mode_o = (mode == MODE_SUPER);
endmodule

// File: rtl/priv_trap_unit_chk.sv
module priv_trap_unit_chk #(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     BW         = 32,
  parameter int unsigned     NUM_BOUNDS = 2,
  parameter logic [XLEN-1:0] TRAP_VEC   = 'h200
) (
  input logic                     clk_i,
  input logic                     rst_n,
  input logic                     syscall_i,
  input logic [XLEN-1:0]          sys_pc_i,
  input logic                     trap_ret_i,
  input logic                     csr_we_i,
  input logic                     mode_o,
  input logic [XLEN-1:0]          next_pc_o,
  input logic [XLEN-1:0]          epc_o,
  input logic                     exc_en_o,
  input logic [NUM_BOUNDS*BW-1:0] bounds_o,
  input logic                     illegal_o
);
  p_sys_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    syscall_i |=> (mode_o && next_pc_o == TRAP_VEC && epc_o == $past(sys_pc_i)));

  p_sys_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    syscall_i |=> !exc_en_o);

  p_ret_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_o && trap_ret_i && !syscall_i) |=> (!mode_o && next_pc_o == $past(epc_o)));

  p_user_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mode_o && csr_we_i && !syscall_i && !trap_ret_i) |=>
      (illegal_o && $stable(mode_o) && $stable(bounds_o) && $stable(epc_o) && $stable(exc_en_o)));

  p_user_ret_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!mode_o && trap_ret_i && !syscall_i) |=>
      (illegal_o && $stable(mode_o) && $stable(next_pc_o) && $stable(exc_en_o)));

  p_sys_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (syscall_i && (csr_we_i || trap_ret_i)) |=> (!illegal_o && $stable(bounds_o) && mode_o));

  p_flag_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    illegal_o |-> $past(!mode_o && !syscall_i && (csr_we_i || trap_ret_i)));
endmodule

bind priv_trap_unit priv_trap_unit_chk #(
  .XLEN(XLEN), .BW(BW), .NUM_BOUNDS(NUM_BOUNDS), .TRAP_VEC(TRAP_VEC)
) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .syscall_i (syscall_i),
  .sys_pc_i  (sys_pc_i),
  .trap_ret_i(trap_ret_i),
  .csr_we_i  (csr_we_i),
  .mode_o    (mode_o),
  .next_pc_o (next_pc_o),
  .epc_o     (epc_o),
  .exc_en_o  (exc_en_o),
  .bounds_o  (bounds_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_priv_trap_unit.sv
`timescale 1ns/1ps
module tb_priv_trap_unit;
  localparam int unsigned XLEN = 32;
  localparam int unsigned BW   = 32;
  localparam int unsigned NB   = 2;
  localparam int unsigned AW   = 4;
  localparam logic [31:0] RVEC = 32'h100;
  localparam logic [31:0] TVEC = 32'h200;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sys, ret, we;
  logic [31:0]   pc, wdata;
  logic [AW-1:0] addr;
  logic          mode, exc, ill;
  logic [31:0]   npc, epc;
  logic [63:0]   bnds;

  always #2.5 clk = ~clk;

  priv_trap_unit #(.XLEN(XLEN), .BW(BW), .NUM_BOUNDS(NB), .AW(AW),
                   .RESET_VEC(RVEC), .TRAP_VEC(TVEC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .syscall_i(sys), .sys_pc_i(pc),
    .trap_ret_i(ret), .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .mode_o(mode), .next_pc_o(npc), .epc_o(epc), .exc_en_o(exc),
    .bounds_o(bnds), .illegal_o(ill));

  typedef struct {
    string       tag;
    logic        mode;
    logic        exc;
    logic        ill;
    logic [31:0] npc;
    logic [31:0] epc;
    logic [63:0] bnds;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;

  // reference model
  logic        m_mode, m_exc, m_shd;
  logic [31:0] m_epc, m_npc;
  logic [31:0] m_bnd [NB];

  function automatic exp_t snap(string tag, logic illv);
    exp_t e;
    e.tag = tag; e.mode = m_mode; e.exc = m_exc; e.ill = illv;
    e.npc = m_npc; e.epc = m_epc; e.bnds = {m_bnd[1], m_bnd[0]};
    return e;
  endfunction

  task automatic compare(exp_t e);
    n_chk++;
    if (mode !== e.mode || exc !== e.exc || ill !== e.ill || npc !== e.npc ||
        epc !== e.epc || bnds !== e.bnds) begin
      n_err++;
      $display("FAIL %s: got mode=%b exc=%b ill=%b npc=%h epc=%h bnds=%h exp mode=%b exc=%b ill=%b npc=%h epc=%h bnds=%h",
               e.tag, mode, exc, ill, npc, epc, bnds,
               e.mode, e.exc, e.ill, e.npc, e.epc, e.bnds);
    end
  endtask

  // driver: one request per cycle, expectation pushed alongside
  task automatic drive(string tag, logic s, logic [31:0] p, logic r,
                       logic w, logic [AW-1:0] a, logic [31:0] d);
    logic illv;
    @(negedge clk);
    sys = s; pc = p; ret = r; we = w; addr = a; wdata = d;
    illv = 1'b0;
    if (s) begin
      m_shd = m_exc; m_exc = 1'b0; m_epc = p; m_npc = TVEC; m_mode = 1'b1;
    end else if (r) begin
      if (m_mode) begin m_npc = m_epc; m_mode = 1'b0; m_exc = m_shd; end
      else illv = 1'b1;
    end else if (w) begin
      if (!m_mode) illv = 1'b1;
      else if (a == 0) begin m_mode = d[0]; m_exc = d[1]; m_shd = d[2]; end
      else if (a == 1) m_epc = d;
      else if (a == 2) m_bnd[0] = d;
      else if (a == 3) m_bnd[1] = d;
    end
    q.push_back(snap(tag, illv));
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sys = 0; ret = 0; we = 0; pc = 0; addr = 0; wdata = 0;
    m_mode = 1'b1; m_exc = 0; m_shd = 0; m_epc = 0; m_npc = RVEC;
    m_bnd[0] = 0; m_bnd[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(snap("R1 reset state", 1'b0));

    drive("R8 sup write bound0",        0, 0, 0, 1, 4'd2, 32'h0000_1000);
    drive("R8 sup write bound1",        0, 0, 0, 1, 4'd3, 32'h0000_8000);
    drive("R8 sup write status",        0, 0, 0, 1, 4'd0, 32'h7);
    drive("R8 sup write epc",           0, 0, 0, 1, 4'd1, 32'h400);
    drive("R4 R3 return to user",       0, 0, 1, 0, 4'd0, 0);
    drive("R5 user write bound0",       0, 0, 0, 1, 4'd2, 32'hdead_beef);
    drive("R5 user write status",       0, 0, 0, 1, 4'd0, 32'h3);
    drive("R9 idle after refusal",      0, 0, 0, 0, 4'd0, 0);
    drive("R6 user return refused",     0, 0, 1, 0, 4'd0, 0);
    drive("R2 R3 syscall from user",    1, 32'h480, 0, 0, 4'd0, 0);
    drive("R8 sup write bound1 again",  0, 0, 0, 1, 4'd3, 32'h0000_9000);
    drive("R8 unmapped address",        0, 0, 0, 1, 4'd15, 32'hffff_ffff);
    drive("R3 R4 return restores exc",  0, 0, 1, 0, 4'd0, 0);
    drive("R7 syscall beats user write",1, 32'h5a0, 0, 1, 4'd2, 32'h5555);
    drive("R7 syscall beats return",    1, 32'h604, 1, 0, 4'd0, 0);
    drive("R10 return drops write",     0, 0, 1, 1, 4'd2, 32'h7777);
    drive("R5 user write epc",          0, 0, 0, 1, 4'd1, 32'h1234);
    drive("R9 idle final",              0, 0, 0, 0, 4'd0, 0);
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule